// File: doc/BRIEF.md
# Region Memory Protection Checker

This block guards every instruction fetch and every data access of a processor core against a set of eight programmable address regions. Each region has a base, a power-of-two size, an enable and a 16-bit select mask. Each region is divided into sixteen equal subregions. Each subregion takes its permission code from one of two permission registers. Its bit in the region's select mask picks which one.

The block has two lookup ports, one for fetches and one for data, and both are checked at the same time. Each port gets a combinational grant in the same cycle as its request. A request that is refused must not be carried out by the core. The refusal is also recorded in a fault register, one cycle after the request, with a fault class and the address of the instruction that caused it. Software programs the regions through a simple write port, where a field select chooses which register a write updates.

Top module: `mpu_checker`

## Requirements
- R1: After reset all regions are disabled, every size reads as 4 KB, both permission registers are zero, and the fault register shows no fault (valid 0, class 0).
- R2: A write with `cfg_we` high takes effect on the clock edge that samples it, and lookups see the new value from the next cycle. Field codes: 0 sets base (`wdata[31:12]`, low 12 bits zero), 1 sets log2 size (`wdata[5:0]`), 2 sets enable (`wdata[0]`), 3 sets select mask (`wdata[15:0]`), 4 sets permission register A, 5 sets permission register B. Codes 0 to 3 address the region given by `cfg_region`.
- R3: Region size is 2^s bytes. A written s below 12 is stored as 12, and a written s above 32 is stored as 32. An enabled region hits when address bits [31:s] equal base bits [31:s].
- R4: The subregion index is address bits [s-1:s-4]. Select-mask bit i set means subregion i uses permission register B, and clear means it uses register A. Region r's field sits in bits [4r+3:4r] of each register.
- R5: A 4-bit permission code has bit0 = read, bit1 = write, bit2 = execute and bit3 = user access. Privileged requests get bits 0 to 2. Unprivileged requests get them only when bit3 is set. Code 0 denies everything.
- R6: A fetch needs execute and a data read needs read, and a data write needs write. A failed check gives class 2 on the fetch side and class 5 on the data side.
- R7: A request hitting no enabled region gives class 1 on the fetch side and class 4 on the data side.
- R8: A request hitting two or more enabled regions gives class 3 on the fetch side and class 6 on the data side. Within one port the priority is multiple-hit, then miss, then permission.
- R9: `if_allow` and `d_allow` are high in the same cycle only for a valid request with no fault, and low otherwise.
- R10: One cycle after a refused request, `fault_valid` is 1 with its class and address. The address is `if_addr` for a fetch fault and `d_pc` for a data fault. A cycle with no refused request gives `fault_valid` 0 and class 0 on the next cycle.
- R11: When both ports are refused in the same cycle, the fetch-side fault is the one recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 3 | Field select code |
| cfg_region | input | 3 | Region index for per-region fields |
| cfg_wdata | input | 32 | Write data |
| if_valid | input | 1 | Fetch request valid |
| if_addr | input | 32 | Fetch address |
| if_priv | input | 1 | Fetch is privileged |
| if_allow | output | 1 | Fetch may proceed |
| d_valid | input | 1 | Data request valid |
| d_addr | input | 32 | Data address |
| d_write | input | 1 | 1 = write, 0 = read |
| d_priv | input | 1 | Data access is privileged |
| d_pc | input | 32 | Address of instruction issuing the data access |
| d_allow | output | 1 | Data access may proceed |
| fault_valid | output | 1 | Registered fault flag |
| fault_class | output | 3 | Registered fault class |
| fault_addr | output | 32 | Registered faulting instruction address |

## Verification
The assertions assume that `cfg_field` and `cfg_region` are never unknown while `cfg_we` is high. They also assume that request signals hold steady across each clock edge. The bench meets both by driving every input only on the falling edge. It never reconfigures a region in the cycle it checks a fault class, except in the one scenario written to test update timing. Multiple-hit cases are created on purpose only by overlapping a 4 GB region with smaller ones, so the priority checks see a known hit count.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int NUM_REG  = 8;
    localparam int NUM_SUB  = 16;
    localparam int ADDR_W   = 32;
    localparam int PERM_W   = 4;
    localparam int REG_IDXW = $clog2(NUM_REG);
    localparam int SUB_IDXW = $clog2(NUM_SUB);
    localparam int MIN_LOG2 = 12;
    localparam int MAX_LOG2 = ADDR_W;

    typedef enum logic [2:0] {
        FLD_BASE = 3'd0,
        FLD_SIZE = 3'd1,
        FLD_EN   = 3'd2,
        FLD_SEL  = 3'd3,
        FLD_PA   = 3'd4,
        FLD_PB   = 3'd5
    } cfg_field_e;

    typedef enum logic [1:0] {
        SF_OK    = 2'd0,
        SF_MISS  = 2'd1,
        SF_PROT  = 2'd2,
        SF_MULTI = 2'd3
    } side_flt_e;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_IMISS  = 3'd1,
        FC_IPROT  = 3'd2,
        FC_IMULTI = 3'd3,
        FC_DMISS  = 3'd4,
        FC_DPROT  = 3'd5,
        FC_DMULTI = 3'd6
    } flt_cls_e;

    typedef struct packed {
        logic [NUM_REG-1:0][ADDR_W-1:0]  base;
        logic [NUM_REG-1:0][5:0]         size;
        logic [NUM_REG-1:0]              en;
        logic [NUM_REG-1:0][NUM_SUB-1:0] sel;
        logic [NUM_REG*PERM_W-1:0]       perm_a;
        logic [NUM_REG*PERM_W-1:0]       perm_b;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        flt_cls_e          cls;
        logic [ADDR_W-1:0] addr;
    } flt_t;
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [2:0]                        cfg_field,
    input  logic [REG_IDXW-1:0]               cfg_region,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [NUM_REG-1:0][ADDR_W-1:0]    base,
    output logic [NUM_REG-1:0][5:0]           size,
    output logic [NUM_REG-1:0]                en,
    output logic [NUM_REG-1:0][NUM_SUB-1:0]   sel,
    output logic [NUM_REG*PERM_W-1:0]         perm_a,
    output logic [NUM_REG*PERM_W-1:0]         perm_b
);
    cfg_t st_d, st_q;
    logic [5:0] size_clamped;

    always_comb begin
        if (cfg_wdata[5:0] < 6'(MIN_LOG2))
            size_clamped = 6'(MIN_LOG2);
        else if (cfg_wdata[5:0] > 6'(MAX_LOG2))
            size_clamped = 6'(MAX_LOG2);
        else
            size_clamped = cfg_wdata[5:0];

        st_d = st_q;
        if (cfg_we) begin
            case (cfg_field)
                FLD_BASE: st_d.base[cfg_region] = {cfg_wdata[ADDR_W-1:MIN_LOG2], {MIN_LOG2{1'b0}}};
                FLD_SIZE: st_d.size[cfg_region] = size_clamped;
                FLD_EN:   st_d.en[cfg_region]   = cfg_wdata[0];
                FLD_SEL:  st_d.sel[cfg_region]  = cfg_wdata[NUM_SUB-1:0];
                FLD_PA:   st_d.perm_a           = cfg_wdata[NUM_REG*PERM_W-1:0];
                FLD_PB:   st_d.perm_b           = cfg_wdata[NUM_REG*PERM_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.size   <= {NUM_REG{6'(MIN_LOG2)}};
        end else begin
            st_q <= st_d;
        end
    end

    assign base   = st_q.base;
    assign size   = st_q.size;
    assign en     = st_q.en;
    assign sel    = st_q.sel;
    assign perm_a = st_q.perm_a;
    assign perm_b = st_q.perm_b;

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_field == FLD_EN) |=> (en[$past(cfg_region)] == $past(cfg_wdata[0])));

    generate
        for (genvar g = 0; g < NUM_REG; g++) begin : g_size_chk
            assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (size[g] >= 6'(MIN_LOG2)) && (size[g] <= 6'(MAX_LOG2)));
        end
    endgenerate
endmodule

// File: rtl/mpu_lookup.sv
module mpu_lookup
    import mpu_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              is_exec,
    input  logic                              is_write,
    input  logic                              priv,
    input  logic [NUM_REG-1:0][ADDR_W-1:0]    base,
    input  logic [NUM_REG-1:0][5:0]           size,
    input  logic [NUM_REG-1:0]                en,
    input  logic [NUM_REG-1:0][NUM_SUB-1:0]   sel,
    input  logic [NUM_REG*PERM_W-1:0]         perm_a,
    input  logic [NUM_REG*PERM_W-1:0]         perm_b,
    output logic [NUM_REG-1:0]                hit_vec,
    output side_flt_e                         flt
);
    logic [PERM_W-1:0] perm_sel;
    logic [2:0]        rights;
    logic              granted;

    always_comb begin
        logic [ADDR_W-1:0]   mask;
        logic [SUB_IDXW-1:0] sub;
        hit_vec  = '0;
        perm_sel = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (size[r] >= 6'(MAX_LOG2))
                mask = '0;
            else
                mask = ~((ADDR_W'(1) << size[r]) - ADDR_W'(1));
            sub = SUB_IDXW'(addr >> (size[r] - 6'(SUB_IDXW)));
            if (en[r] && (((addr ^ base[r]) & mask) == '0)) begin
                hit_vec[r] = 1'b1;
                perm_sel   = perm_sel | (sel[r][sub] ? perm_b[PERM_W*r +: PERM_W]
                                                     : perm_a[PERM_W*r +: PERM_W]);
            end
        end
    end

    always_comb begin
        rights = (priv || perm_sel[3]) ? perm_sel[2:0] : 3'b000;
        if (is_exec)
            granted = rights[2];
        else if (is_write)
            granted = rights[1];
        else
            granted = rights[0];

        if ($countones(hit_vec) > 1)
            flt = SF_MULTI;
        else if (hit_vec == '0)
            flt = SF_MISS;
        else if (!granted)
            flt = SF_PROT;
        else
            flt = SF_OK;
    end

    assert_multi_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $countones(hit_vec) > 1) |-> (flt == SF_MULTI));

    assert_miss_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_vec == '0) |-> (flt == SF_MISS));
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
    import mpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_field,
    input  logic [2:0]  cfg_region,
    input  logic [31:0] cfg_wdata,
    input  logic        if_valid,
    input  logic [31:0] if_addr,
    input  logic        if_priv,
    output logic        if_allow,
    input  logic        d_valid,
    input  logic [31:0] d_addr,
    input  logic        d_write,
    input  logic        d_priv,
    input  logic [31:0] d_pc,
    output logic        d_allow,
    output logic        fault_valid,
    output logic [2:0]  fault_class,
    output logic [31:0] fault_addr
);
    logic [NUM_REG-1:0][ADDR_W-1:0]  base;
    logic [NUM_REG-1:0][5:0]         size;
    logic [NUM_REG-1:0]              en;
    logic [NUM_REG-1:0][NUM_SUB-1:0] sel;
    logic [NUM_REG*PERM_W-1:0]       perm_a, perm_b;
    logic [NUM_REG-1:0]              i_hits, d_hits;
    side_flt_e                       i_flt, d_flt;
    flt_t                            flt_d, flt_q;
    logic                            i_bad, d_bad;

    mpu_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_region(cfg_region), .cfg_wdata(cfg_wdata),
        .base(base), .size(size), .en(en), .sel(sel),
        .perm_a(perm_a), .perm_b(perm_b)
    );

    mpu_lookup u_ilook (
        .clk(clk), .rst_n(rst_n), .req_valid(if_valid), .addr(if_addr),
        .is_exec(1'b1), .is_write(1'b0), .priv(if_priv),
        .base(base), .size(size), .en(en), .sel(sel),
        .perm_a(perm_a), .perm_b(perm_b), .hit_vec(i_hits), .flt(i_flt)
    );

    mpu_lookup u_dlook (
        .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .addr(d_addr),
        .is_exec(1'b0), .is_write(d_write), .priv(d_priv),
        .base(base), .size(size), .en(en), .sel(sel),
        .perm_a(perm_a), .perm_b(perm_b), .hit_vec(d_hits), .flt(d_flt)
    );

    assign i_bad    = if_valid && (i_flt != SF_OK);
    assign d_bad    = d_valid && (d_flt != SF_OK);
    assign if_allow = if_valid && (i_flt == SF_OK);
    assign d_allow  = d_valid && (d_flt == SF_OK);

    always_comb begin
        flt_d = '0;
        if (i_bad) begin
            flt_d.valid = 1'b1;
            flt_d.addr  = if_addr;
            case (i_flt)
                SF_MULTI: flt_d.cls = FC_IMULTI;
                SF_MISS:  flt_d.cls = FC_IMISS;
                default:  flt_d.cls = FC_IPROT;
            endcase
        end else if (d_bad) begin
            flt_d.valid = 1'b1;
            flt_d.addr  = d_pc;
            case (d_flt)
                SF_MULTI: flt_d.cls = FC_DMULTI;
                SF_MISS:  flt_d.cls = FC_DMISS;
                default:  flt_d.cls = FC_DPROT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign fault_valid = flt_q.valid;
    assign fault_class = flt_q.cls;
    assign fault_addr  = flt_q.addr;

    assert_fault_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_allow) |=> fault_valid);

    assert_quiet_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(if_valid && !if_allow) && !(d_valid && !d_allow)) |=> (!fault_valid && fault_class == FC_NONE));

    assert_fetch_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (if_valid && !if_allow) |=> (fault_addr == $past(if_addr) && fault_class != FC_NONE && fault_class < FC_DMISS));

    assert_block_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (if_allow -> $countones(i_hits) == 1) && (d_allow -> $countones(d_hits) == 1));
endmodule

// File: tb/mpu_checker_tb.sv
module mpu_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_field = '0;
    logic [2:0]  cfg_region = '0;
    logic [31:0] cfg_wdata = '0;
    logic        if_valid = 1'b0;
    logic [31:0] if_addr = '0;
    logic        if_priv = 1'b0;
    logic        if_allow;
    logic        d_valid = 1'b0;
    logic [31:0] d_addr = '0;
    logic        d_write = 1'b0;
    logic        d_priv = 1'b0;
    logic [31:0] d_pc = '0;
    logic        d_allow;
    logic        fault_valid;
    logic [2:0]  fault_class;
    logic [31:0] fault_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mpu_checker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_region(cfg_region), .cfg_wdata(cfg_wdata),
        .if_valid(if_valid), .if_addr(if_addr), .if_priv(if_priv), .if_allow(if_allow),
        .d_valid(d_valid), .d_addr(d_addr), .d_write(d_write), .d_priv(d_priv),
        .d_pc(d_pc), .d_allow(d_allow),
        .fault_valid(fault_valid), .fault_class(fault_class), .fault_addr(fault_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] fld, input logic [2:0] reg_i, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_field = fld; cfg_region = reg_i; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input string req,
                          input logic iv, input logic [31:0] ia, input logic ip,
                          input logic dv, input logic [31:0] da, input logic dw,
                          input logic dp, input logic [31:0] dpc,
                          input logic exp_ia, input logic exp_da,
                          input logic [2:0] exp_cls, input logic [31:0] exp_addr);
        @(negedge clk);
        if_valid = iv; if_addr = ia; if_priv = ip;
        d_valid = dv; d_addr = da; d_write = dw; d_priv = dp; d_pc = dpc;
        #1;
        check({req, " if_allow"}, 32'(if_allow), 32'(exp_ia));
        check({req, " d_allow"}, 32'(d_allow), 32'(exp_da));
        @(posedge clk); #1;
        check({req, " fault_valid"}, 32'(fault_valid), 32'(exp_cls != 3'd0));
        check({req, " fault_class"}, 32'(fault_class), 32'(exp_cls));
        if (exp_cls != 3'd0) check({req, " fault_addr"}, fault_addr, exp_addr);
        @(negedge clk);
        if_valid = 1'b0; d_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 fault_valid at reset", 32'(fault_valid), 32'd0);
        check("R1 fault_class at reset", 32'(fault_class), 32'd0);
        access("R1 R7 fetch with no regions", 1, 32'h0, 1, 0, 0, 0, 0, 0, 0, 0, 3'd1, 32'h0);
        access("R1 R7 data with no regions", 0, 0, 0, 1, 32'h100, 0, 1, 32'hABC, 0, 0, 3'd4, 32'hABC);
    endtask

    task automatic t_config;
        cfg_write(3'd0, 3'd0, 32'h0000_0000);
        cfg_write(3'd1, 3'd0, 32'd14);
        cfg_write(3'd3, 3'd0, 32'h0000_A0F5);
        cfg_write(3'd4, 3'd0, 32'h0000_077D);
        cfg_write(3'd5, 3'd0, 32'h0000_0001);
        cfg_write(3'd0, 3'd1, 32'h0001_0000);
        cfg_write(3'd1, 3'd1, 32'd16);
        cfg_write(3'd2, 3'd1, 32'd1);
        cfg_write(3'd0, 3'd2, 32'h0008_0000);
        cfg_write(3'd1, 3'd2, 32'd3);
        cfg_write(3'd2, 3'd2, 32'd1);
    endtask

    task automatic t_enable_timing;
        @(negedge clk);
        cfg_we = 1'b1; cfg_field = 3'd2; cfg_region = 3'd0; cfg_wdata = 32'd1;
        if_valid = 1'b1; if_addr = 32'h400; if_priv = 1'b0;
        #1;
        check("R2 fetch before enable edge", 32'(if_allow), 32'd0);
        @(posedge clk); #1;
        check("R2 fetch after enable edge", 32'(if_allow), 32'd1);
        @(negedge clk);
        cfg_we = 1'b0; if_valid = 1'b0;
    endtask

    task automatic t_subregions;
        access("R4 R6 sub0 uses B, no execute", 1, 32'h000, 1, 0, 0, 0, 0, 0, 0, 0, 3'd2, 32'h000);
        access("R4 R5 sub1 uses A, user execute", 1, 32'h400, 0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 0);
        access("R6 write without write right", 0, 0, 0, 1, 32'h400, 1, 1, 32'h1234, 0, 0, 3'd5, 32'h1234);
        access("R4 sub9 uses A user read", 0, 0, 0, 1, 32'h2400, 0, 0, 32'h0, 0, 1, 3'd0, 0);
        access("R4 R5 sub13 uses B no user", 0, 0, 0, 1, 32'h3400, 0, 0, 32'h2000, 0, 0, 3'd5, 32'h2000);
        access("R5 sub13 privileged read", 0, 0, 0, 1, 32'h3400, 0, 1, 32'h2000, 0, 1, 3'd0, 0);
        access("R7 data past region 0", 0, 0, 0, 1, 32'h4000, 0, 1, 32'h3000, 0, 0, 3'd4, 32'h3000);
    endtask

    task automatic t_sizes;
        access("R3 last word of 64KB region", 0, 0, 0, 1, 32'h1FFFC, 0, 1, 32'h10, 0, 1, 3'd0, 0);
        access("R3 first word past 64KB region", 0, 0, 0, 1, 32'h20000, 0, 1, 32'h14, 0, 0, 3'd4, 32'h14);
        access("R5 user denied without user bit", 0, 0, 0, 1, 32'h10000, 0, 0, 32'h18, 0, 0, 3'd5, 32'h18);
        access("R3 size clamped to 4KB hit", 1, 32'h80FFC, 1, 0, 0, 0, 0, 0, 1, 0, 3'd0, 0);
        access("R3 size clamped to 4KB miss", 1, 32'h81000, 1, 0, 0, 0, 0, 0, 0, 0, 3'd1, 32'h81000);
    endtask

    task automatic t_multi;
        cfg_write(3'd0, 3'd3, 32'h0000_0000);
        cfg_write(3'd1, 3'd3, 32'd40);
        cfg_write(3'd2, 3'd3, 32'd1);
        access("R8 fetch multi-hit", 1, 32'h10000, 1, 0, 0, 0, 0, 0, 0, 0, 3'd3, 32'h10000);
        access("R8 data multi-hit", 0, 0, 0, 1, 32'h80000, 0, 1, 32'h44, 0, 0, 3'd6, 32'h44);
        access("R5 R3 code 0 denies in 4GB region", 0, 0, 0, 1, 32'h5000_0000, 0, 1, 32'h48, 0, 0, 3'd5, 32'h48);
        cfg_write(3'd2, 3'd3, 32'd0);
        access("R2 region disabled again", 0, 0, 0, 1, 32'h1FFFC, 0, 1, 32'h4C, 0, 1, 3'd0, 0);
    endtask

    task automatic t_both_sides;
        access("R11 both ports miss", 1, 32'h4000, 1, 1, 32'h4000, 0, 1, 32'h5555, 0, 0, 3'd1, 32'h4000);
        access("R10 idle cycle clears fault", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd0, 0);
        access("R9 R10 both allowed", 1, 32'h400, 1, 1, 32'h2400, 0, 1, 32'h60, 1, 1, 3'd0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_enable_timing();
        t_subregions();
        t_sizes();
        t_multi();
        t_both_sides();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule